// File: doc/BRIEF.md
# Power-On Reset Sequencer

This block produces the internal reset and a clock-ready flag for a small microcontroller. When the supply comes up, it first waits out a fixed settling period. It then waits for the supply to pass the brown-out level, if that check is enabled. Next it counts a start-up delay whose length is chosen by a 2-bit code. Internal reset is released only when the delay has run out and the external reset pin is high.

The analog comparators, the oscillator and the fuse bits lie outside the block. They appear here as synchronous inputs. The power-on comparator drives the synchronous active-high `rst` input, and holding it high keeps the sequencer at the start of its settling period. The same selectable delay is applied again in two other cases: when the supply recovers after a brown-out, and when the core wakes from power-down. On a wake-up only the clock-ready flag drops, and internal reset stays low. A 2-bit output reports what caused the most recent reset or wake event.

Top module: `rst_sequencer`

## Requirements
- R1: While `rst` is high, `int_rst` is 1, `clk_stable` is 0 and `reset_cause` is 0 (power-on) from the first clock edge on.
- R2: With the brown-out check passing or disabled, `int_rst` falls at the clock edge numbered INIT_CYC + L, counting edges from the first edge with `rst` low. L is the delay selected by `sut_sel`.
- R3: `sut_sel` values 0, 1, 2 and 3 select the delays SUT0, SUT1, SUT2 and SUT3. The code is captured when a delay begins, and later changes do not alter a delay that is already running.
- R4: With `bod_en` high and `bod_ok` low once the settling period ends, the delay waits. If `bod_ok` is first seen high at edge d, which is later than edge INIT_CYC, then `int_rst` falls at edge d + L.
- R5: If `bod_ok` rises before the settling period ends, the delay still starts only when that period ends. The total time is INIT_CYC + L.
- R6: `rst_pin_n` passes through a 2-stage synchronizer. A change of the pin before edge e reaches `int_rst` at edge e+2. A low pin holds `int_rst` high after the time-out. A low pin in normal running raises `int_rst`, leaves `clk_stable` at 1 and sets `reset_cause` to 2 (pin).
- R7: With `bod_en` high, a low `bod_ok` at any point after the settling period sets `int_rst` to 1 and `clk_stable` to 0 at the next edge, and sets `reset_cause` to 1 (brown-out). Recovery runs the selected delay again, starting from the edge at which `bod_ok` is seen high.
- R8: A one-cycle `wake` pulse during normal running drops `clk_stable` at the next edge for L edges in total and sets `reset_cause` to 3 (wake). `int_rst` stays 0 throughout.
- R9: When `bod_en` is 0, `bod_ok` has no effect on `int_rst`.
- R10: `clk_stable` is 0 until the start-up delay has completed, and is never 1 while the sequence is still counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Power-on comparator flag; high holds the sequence at its start (synchronous) |
| bod_en | input | 1 | Enables the brown-out check |
| bod_ok | input | 1 | Supply is above the brown-out threshold |
| rst_pin_n | input | 1 | External reset pin, active low, asynchronous |
| wake | input | 1 | Wake request from power-down (one-cycle pulse) |
| sut_sel | input | 2 | Start-up delay selection code |
| int_rst | output | 1 | Internal reset, active high, registered |
| clk_stable | output | 1 | Clock has settled after the start-up delay |
| reset_cause | output | 2 | Last event: 0 power-on, 1 brown-out, 2 pin, 3 wake |

## Verification
The design registers every output from the next state. A change on `bod_ok` or `wake` before edge e therefore shows at edge e. A pin change shows two edges later, because it passes through the synchronizer first. Start-up delays complete at edge INIT_CYC + L, or at d + L when the brown-out check gates the start. The bench drives inputs on falling edges and samples on the falling edge after each rising edge. It counts rising edges up to the first sample where the output has changed and compares that count with the edge number the formula gives. Settling, brown-out and pin release times are swept across both sides of the settling boundary.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
  typedef enum logic [2:0] {
    ST_INIT    = 3'd0,
    ST_WAITBOD = 3'd1,
    ST_DELAY   = 3'd2,
    ST_HOLD    = 3'd3,
    ST_RUN     = 3'd4,
    ST_WAKE    = 3'd5
  } seq_state_e;

  typedef enum logic [1:0] {
    CAUSE_POWER = 2'd0,
    CAUSE_BROWN = 2'd1,
    CAUSE_PIN   = 2'd2,
    CAUSE_WAKE  = 2'd3
  } cause_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
  parameter int unsigned STAGES = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rstseq_timer.sv
module rstseq_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          clr,
  input  logic [CW-1:0] len,
  output logic          done
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (en)    cnt <= cnt + CW'(1);
  end

  assign done = en && (cnt == len - CW'(1));

  // R3: a running count never passes the selected length
  a_r3_count_in_range: assert property (@(posedge clk) disable iff (rst)
    (en && !clr && len != '0) |-> (cnt < len));
endmodule

// File: rtl/rst_sequencer.sv
module rst_sequencer
  import rstseq_pkg::*;
#(
  parameter int unsigned INIT_CYC    = 2860,
  parameter int unsigned SUT0        = 16,
  parameter int unsigned SUT1        = 512,
  parameter int unsigned SUT2        = 4096,
  parameter int unsigned SUT3        = 16384,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bod_en,
  input  logic       bod_ok,
  input  logic       rst_pin_n,
  input  logic       wake,
  input  logic [1:0] sut_sel,
  output logic       int_rst,
  output logic       clk_stable,
  output logic [1:0] reset_cause
);
  localparam int unsigned SUT_TAB [4] = '{SUT0, SUT1, SUT2, SUT3};
  localparam int unsigned MAXC = max_u(max_u(INIT_CYC, max_u(SUT0, SUT1)), max_u(SUT2, SUT3));
  localparam int unsigned CW   = $clog2(MAXC + 1);

  seq_state_e    state, state_n;
  cause_e        cause_q, cause_n;
  logic [1:0]    sel_q;
  logic          load_sel;
  logic          pin_s;
  logic          brown_ok, brown_drop;
  logic          tmr_en, tmr_clr, tmr_done;
  logic [CW-1:0] tmr_len;

  rstseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pin_sync (
    .clk(clk), .rst(rst), .d(rst_pin_n), .q(pin_s)
  );

  assign brown_ok   = !bod_en || bod_ok;
  assign brown_drop = bod_en && !bod_ok;

  assign tmr_en  = (state == ST_INIT) || (state == ST_DELAY) || (state == ST_WAKE);
  assign tmr_clr = (state_n != state);
  assign tmr_len = (state == ST_INIT) ? CW'(INIT_CYC) : CW'(SUT_TAB[sel_q]);

  rstseq_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst(rst), .en(tmr_en), .clr(tmr_clr), .len(tmr_len), .done(tmr_done)
  );

  always_comb begin
    state_n  = state;
    cause_n  = cause_q;
    load_sel = 1'b0;
    unique case (state)
      ST_INIT: if (tmr_done) begin
        if (brown_ok) begin
          state_n  = ST_DELAY;
          load_sel = 1'b1;
        end else begin
          state_n = ST_WAITBOD;
        end
      end
      ST_WAITBOD: if (brown_ok) begin
        state_n  = ST_DELAY;
        load_sel = 1'b1;
      end
      ST_DELAY: if (tmr_done) state_n = pin_s ? ST_RUN : ST_HOLD;
      ST_HOLD:  if (pin_s) state_n = ST_RUN;
      ST_RUN: begin
        if (!pin_s) begin
          state_n = ST_HOLD;
          cause_n = CAUSE_PIN;
        end else if (wake) begin
          state_n  = ST_WAKE;
          cause_n  = CAUSE_WAKE;
          load_sel = 1'b1;
        end
      end
      ST_WAKE: if (tmr_done) state_n = ST_RUN;
      default: state_n = ST_INIT;
    endcase
    if (brown_drop && state != ST_INIT) begin
      state_n  = ST_WAITBOD;
      load_sel = 1'b0;
      if (state != ST_WAITBOD) cause_n = CAUSE_BROWN;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_INIT;
      cause_q    <= CAUSE_POWER;
      sel_q      <= 2'd0;
      int_rst    <= 1'b1;
      clk_stable <= 1'b0;
    end else begin
      state      <= state_n;
      cause_q    <= cause_n;
      if (load_sel) sel_q <= sut_sel;
      int_rst    <= !((state_n == ST_RUN) || (state_n == ST_WAKE));
      clk_stable <= (state_n == ST_RUN) || (state_n == ST_HOLD);
    end
  end

  assign reset_cause = cause_q;

  // R1: reset state appears one edge after rst is seen
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (int_rst && !clk_stable && reset_cause == 2'd0));

  // R7: a brown-out reasserts reset and drops the clock flag at the next edge
  a_r7_brownout_reasserts: assert property (@(posedge clk) disable iff (rst)
    (bod_en && !bod_ok) |=> (int_rst && !clk_stable));

  // R6: a low synchronized pin keeps internal reset high
  a_r6_pin_holds_reset: assert property (@(posedge clk) disable iff (rst)
    (!pin_s && state != ST_WAKE) |=> int_rst);

  // R8: the wake delay never asserts internal reset
  a_r8_wake_no_reset: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAKE) |-> (!int_rst && !clk_stable));

  // R10: clock flag only once the delay has completed
  a_r10_stable_after_delay: assert property (@(posedge clk) disable iff (rst)
    clk_stable |-> (state == ST_RUN || state == ST_HOLD));
endmodule

// File: tb/rst_sequencer_test.sv
module rst_sequencer_test;
  localparam int INIT = 12;
  localparam int L0 = 3, L1 = 5, L2 = 8, L3 = 13;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bod_en = 1'b0, bod_ok = 1'b1, rst_pin_n = 1'b1, wake = 1'b0;
  logic [1:0] sut_sel = 2'd0;
  logic int_rst, clk_stable;
  logic [1:0] reset_cause;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  rst_sequencer #(.INIT_CYC(INIT), .SUT0(L0), .SUT1(L1), .SUT2(L2), .SUT3(L3)) uut (
    .clk(clk), .rst(rst), .bod_en(bod_en), .bod_ok(bod_ok), .rst_pin_n(rst_pin_n),
    .wake(wake), .sut_sel(sut_sel), .int_rst(int_rst), .clk_stable(clk_stable),
    .reset_cause(reset_cause)
  );

  function automatic int lenof(input int s);
    case (s)
      0: return L0;
      1: return L1;
      2: return L2;
      default: return L3;
    endcase
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  int early_stable;

  // bod_d / pin_p: input goes high after that many edges (0 = high from release)
  task automatic power_up(input int sel, input bit ben, input int bod_d, input int pin_p,
                          output int n);
    rst = 1'b1; sut_sel = 2'(sel); bod_en = ben; wake = 1'b0;
    bod_ok = (bod_d == 0); rst_pin_n = (pin_p == 0);
    repeat (3) @(negedge clk);
    rst = 1'b0; n = 0; early_stable = 0;
    while (int_rst && n < 300) begin
      @(posedge clk); @(negedge clk); n++;
      if (int_rst && clk_stable && pin_p == 0) early_stable++;
      if (n == bod_d) bod_ok = 1'b1;
      if (n == pin_p) rst_pin_n = 1'b1;
    end
  endtask

  // edges until the chosen output reaches val; also counts int_rst highs on the way
  int rst_seen;
  task automatic wait_for(input bit use_stable, input bit val, output int n);
    n = 0; rst_seen = 0;
    do begin
      @(posedge clk); @(negedge clk); n++;
      if (int_rst) rst_seen++;
    end while (((use_stable ? clk_stable : int_rst) != val) && n < 300);
  endtask

  initial begin
    int n;
    repeat (2) @(negedge clk);
    chk("R1 int_rst in reset", int_rst, 1);
    chk("R1 clk_stable in reset", clk_stable, 0);
    chk("R1 cause in reset", reset_cause, 0);

    // R2 / R3 / R9: each code, brown-out check on (passing) and off (flag low)
    for (int s = 0; s < 4; s++) begin
      for (int b = 0; b < 2; b++) begin
        power_up(s, b[0], (b == 1) ? 0 : 999, 0, n);
        chk(b ? "R2 R3 release edge" : "R9 R3 release edge, flag ignored", n, INIT + lenof(s));
        chk("R10 no early clk_stable", early_stable, 0);
        chk("R10 clk_stable at release", clk_stable, 1);
        chk("R2 cause power-on", reset_cause, 0);
      end
    end

    // R4 / R5: brown-out threshold crossed at swept times
    for (int d = 0; d <= 20; d++) begin
      power_up(1, 1'b1, d, 0, n);
      chk((d + 1 <= INIT) ? "R5 threshold before init end" : "R4 delay waits for threshold",
          n, imax(INIT, d + 1) + L1);
    end

    // R6: pin released at swept times
    for (int p = 0; p <= 20; p++) begin
      power_up(0, 1'b0, 999, p, n);
      chk("R6 pin extends reset", n, imax(INIT + L0, p + 3));
    end

    // running system, sel 2
    power_up(2, 1'b1, 0, 0, n);
    chk("R2 release edge sel2", n, INIT + L2);

    // R8: wake with code 3
    sut_sel = 2'd3; wake = 1'b1;
    @(posedge clk); @(negedge clk);
    wake = 1'b0;
    chk("R8 clk_stable drops", clk_stable, 0);
    chk("R8 cause wake", reset_cause, 3);
    chk("R8 int_rst stays low", int_rst, 0);
    wait_for(1'b1, 1'b1, n);
    chk("R8 wake delay edges", n + 1, 1 + L3);
    chk("R8 no reset during wake", rst_seen, 0);

    // R6: pin pulse while running
    rst_pin_n = 1'b0;
    wait_for(1'b0, 1'b1, n);
    chk("R6 pin to reset latency", n, 3);
    chk("R6 clk_stable kept", clk_stable, 1);
    chk("R6 cause pin", reset_cause, 2);
    rst_pin_n = 1'b1;
    wait_for(1'b0, 1'b0, n);
    chk("R6 pin release latency", n, 3);

    // R9: flag low with check disabled
    bod_en = 1'b0; bod_ok = 1'b0;
    repeat (10) @(negedge clk);
    chk("R9 flag ignored", int_rst, 0);
    chk("R9 cause unchanged", reset_cause, 2);
    bod_ok = 1'b1;

    // R7 / R3: brown-out while running, code changed mid-delay
    bod_en = 1'b1; bod_ok = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R7 reset reasserted", int_rst, 1);
    chk("R7 clk_stable dropped", clk_stable, 0);
    chk("R7 cause brown-out", reset_cause, 1);
    repeat (5) @(negedge clk);
    chk("R7 held while low", int_rst, 1);
    sut_sel = 2'd0; bod_ok = 1'b1;
    @(posedge clk); @(negedge clk);
    sut_sel = 2'd3;
    wait_for(1'b0, 1'b0, n);
    chk("R7 R3 recovery edges, code latched", n + 1, 1 + L0);
    chk("R7 cause kept", reset_cause, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule